// File: doc/BRIEF.md
# Hart memory region permission checker

This block guards the physical address space of one processor hart that runs at machine, supervisor or user privilege. It holds a small, parameterised set of region entries, each a half-open address window `[base, limit)` with a configuration byte of read, write, execute, lock and machine-only flags. A register write port, honoured only when the writer is in machine mode, programs the entries and a global lockdown flag. A combinational check port takes an address, an access kind and a privilege level. In the same cycle it returns a fault flag, a hit flag and the index of the entry that decided the outcome.

The lock flag and the machine-only flag are independent controls. Lock freezes an entry until reset. The machine-only flag selects whose permissions the read/write/execute bits describe. While lockdown is off, the block behaves as classic region protection, and an entry with the machine-only flag set applies its permissions to every privilege level. Once lockdown is set, machine mode loses its implicit access to every region. The machine-only flag then splits the entries into machine-mode regions and supervisor/user regions. Lockdown is sticky until reset. A build parameter can tie the machine-only flag to zero, which gives exactly the classic behaviour.

Top module: `hart_prot_checker`

## Requirements
- R1: After reset every entry reads back configuration 0x00, base 0 and limit 0, and `lockdown` reads 0.
- R2: A machine-mode (`wr_priv` = 3) write to an unlocked entry stores into that entry and shows on the readback port one clock after the capturing edge. `wr_kind` selects the target: 0 is the configuration, 1 is base and 2 is limit. The configuration byte keeps R at bit 0, W at bit 1, X at bit 2, M (machine-only) at bit 3 and L (lock) at bit 7, and bits 4 to 6 read as zero.
- R3: Writes issued with `wr_priv` of 0 (user) or 1 (supervisor) change no entry and do not change the lockdown flag.
- R4: While an entry's L bit is 1, writes to its configuration, base and limit are ignored until reset.
- R5: A machine-mode write with `wr_kind` = 3 and `wr_data[0]` = 1 sets the lockdown flag. No write clears the flag, and only reset clears it.
- R6: An entry takes part in matching only when at least one of its R, W or X bits is 1. It matches when base <= address < limit. When several entries match, the lowest index decides, and `chk_hit` and `chk_idx` report that entry in the same cycle.
- R7: With lockdown off and an entry with M=0 and L=0, machine mode (`chk_priv` = 3) is always allowed. Supervisor and user accesses are allowed only if the entry's bit for the access kind is 1. `chk_acc` codes 0, 1 and 2 mean read, write and execute.
- R8: With lockdown off and an entry with L=1 or M=1, every privilege level is allowed only if the entry's bit for the access kind is 1.
- R9: With lockdown on, an M=1 entry gives machine mode its R/W/X bits and faults all supervisor and user accesses. An M=0 entry gives supervisor and user its R/W/X bits and faults all machine-mode accesses. L has no effect on the permission, so M,R,W,X = 1,0,0,1 is a machine-mode execute-only region.
- R10: When no entry matches, machine-mode accesses are allowed. Supervisor and user accesses fault if at least one entry is enabled, and are allowed if none is.
- R11: With `HAS_MBIT` = 0, the M bit always reads back as 0 and has no effect on any permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_priv | input | 2 | Privilege of the writer (0 user, 1 supervisor, 3 machine) |
| wr_kind | input | 2 | Write target: 0 configuration, 1 base, 2 limit, 3 lockdown |
| wr_idx | input | IDX_W | Entry selected by the write |
| wr_data | input | ADDR_W | Write data |
| rd_idx | input | IDX_W | Entry shown on the readback outputs |
| rd_cfg | output | 8 | Configuration byte of the selected entry |
| rd_base | output | ADDR_W | Base address of the selected entry |
| rd_limit | output | ADDR_W | Limit address (exclusive) of the selected entry |
| lockdown | output | 1 | Global sticky lockdown flag |
| chk_addr | input | ADDR_W | Address being checked |
| chk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_priv | input | 2 | Privilege of the access |
| chk_fault | output | 1 | 1 when the access is denied |
| chk_hit | output | 1 | 1 when an entry matched |
| chk_idx | output | IDX_W | Index of the deciding entry (0 when no hit) |

## Verification
Check results are combinational: the bench moves the check inputs just after a falling edge and samples `chk_fault`, `chk_hit` and `chk_idx` two time units later, with no clock in between. Register writes go through one flop stage. The bench holds a write across one rising edge and reads the effect on the readback port and `lockdown` only after that edge, at the next falling edge. Its reference model updates on the same rising edge, and it is compared against the readback port at every falling edge, so any write that takes effect a cycle early or late, or that should have been dropped, shows up as a mismatch.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef enum logic [1:0] {
        WK_CFG   = 2'd0,
        WK_BASE  = 2'd1,
        WK_LIMIT = 2'd2,
        WK_MODE  = 2'd3
    } wr_kind_e;

    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic [1:0] PRIV_MACH  = 2'd3;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;

    // Stored form of one entry's configuration byte
    typedef struct packed {
        logic lock;
        logic monly;
        logic x;
        logic w;
        logic r;
    } ecfg_t;

    function automatic ecfg_t cfg_from_byte(input logic lock_bit,
                                            input logic [3:0] low_bits,
                                            input logic keep_m);
        ecfg_t c;
        c.lock  = lock_bit;
        c.monly = low_bits[3] & keep_m;
        c.x     = low_bits[2];
        c.w     = low_bits[1];
        c.r     = low_bits[0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input ecfg_t c);
        return {c.lock, 3'b000, c.monly, c.x, c.w, c.r};
    endfunction

endpackage

// File: rtl/hpc_regs.sv
module hpc_regs
    import hpc_pkg::*;
#(
    parameter int NUM      = 4,
    parameter int AW       = 32,
    parameter bit HAS_MBIT = 1'b1,
    parameter int IW       = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_priv,
    input  logic [1:0]               wr_kind,
    input  logic [IW-1:0]            wr_idx,
    input  logic [AW-1:0]            wr_data,
    output ecfg_t [NUM-1:0]          cfg_o,
    output logic [NUM-1:0][AW-1:0]   base_o,
    output logic [NUM-1:0][AW-1:0]   limit_o,
    output logic                     lockdown_o
);

    typedef struct packed {
        ecfg_t [NUM-1:0]         cfg;
        logic [NUM-1:0][AW-1:0]  base;
        logic [NUM-1:0][AW-1:0]  limit;
        logic                    lockdown;
    } state_t;

    state_t   s_d, s_q;
    wr_kind_e kind;
    logic     mach_wr;
    logic     idx_ok;

    assign kind    = wr_kind_e'(wr_kind);
    assign mach_wr = wr_en && (wr_priv == PRIV_MACH);
    assign idx_ok  = (int'(wr_idx) < NUM);

    always_comb begin
        s_d = s_q;
        if (mach_wr) begin
            if (kind == WK_MODE) begin
                if (wr_data[0]) begin
                    s_d.lockdown = 1'b1;
                end
            end else if (idx_ok && !s_q.cfg[wr_idx].lock) begin
                unique case (kind)
                    WK_CFG:   s_d.cfg[wr_idx]   = cfg_from_byte(wr_data[7], wr_data[3:0], HAS_MBIT);
                    WK_BASE:  s_d.base[wr_idx]  = wr_data;
                    WK_LIMIT: s_d.limit[wr_idx] = wr_data;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o      = s_q.cfg;
    assign base_o     = s_q.base;
    assign limit_o    = s_q.limit;
    assign lockdown_o = s_q.lockdown;

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lockdown |=> s_q.lockdown)
        else $error("lockdown flag cleared"); // R5

    AST_LOWPRIV_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_priv != PRIV_MACH)) |=> $stable(s_q))
        else $error("non-machine write changed state"); // R3

    for (genvar g = 0; g < NUM; g++) begin : g_lock_chk
        AST_LOCKED_ENTRY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cfg[g].lock |=> ($stable(s_q.cfg[g]) && $stable(s_q.base[g]) && $stable(s_q.limit[g])))
            else $error("locked entry changed"); // R4
    end

endmodule

// File: rtl/hpc_perm.sv
module hpc_perm
    import hpc_pkg::*;
#(
    parameter int AW = 32
) (
    input  ecfg_t          cfg,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  limit,
    input  logic [AW-1:0]  addr,
    input  logic [1:0]     acc,
    input  logic [1:0]     priv,
    input  logic           lockdown,
    output logic           match_o,
    output logic           allow_o,
    output logic           enabled_o
);

    logic perm_bit;
    logic is_mach;
    logic in_range;

    assign enabled_o = cfg.r | cfg.w | cfg.x;
    assign in_range  = (addr >= base) && (addr < limit);
    assign match_o   = enabled_o && in_range;
    assign is_mach   = (priv == PRIV_MACH);

    always_comb begin
        unique case (acc)
            ACC_READ:  perm_bit = cfg.r;
            ACC_WRITE: perm_bit = cfg.w;
            default:   perm_bit = cfg.x;
        endcase
    end

    always_comb begin
        if (!lockdown) begin
            if (cfg.monly || cfg.lock) begin
                allow_o = perm_bit;
            end else begin
                allow_o = is_mach || perm_bit;
            end
        end else begin
            allow_o = (cfg.monly == is_mach) && perm_bit;
        end
    end

endmodule

// File: rtl/hpc_prio.sv
module hpc_prio #(
    parameter int NUM = 4,
    parameter int IW  = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] match_i,
    input  logic [NUM-1:0] allow_i,
    input  logic [NUM-1:0] enabled_i,
    input  logic           is_mach,
    output logic           hit_o,
    output logic [IW-1:0]  idx_o,
    output logic           fault_o
);

    logic sel_allow;

    always_comb begin
        hit_o     = 1'b0;
        idx_o     = '0;
        sel_allow = 1'b0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o     = 1'b1;
                idx_o     = IW'(i);
                sel_allow = allow_i[i];
            end
        end
        if (hit_o) begin
            fault_o = !sel_allow;
        end else begin
            fault_o = !(is_mach || !(|enabled_i));
        end
    end

endmodule

// File: rtl/hart_prot_checker.sv
module hart_prot_checker
    import hpc_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 32,
    parameter bit HAS_MBIT    = 1'b1,
    parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_priv,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_cfg,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_limit,
    output logic              lockdown,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [1:0]        chk_acc,
    input  logic [1:0]        chk_priv,
    output logic              chk_fault,
    output logic              chk_hit,
    output logic [IDX_W-1:0]  chk_idx
);

    ecfg_t [NUM_ENTRIES-1:0]             cfg;
    logic  [NUM_ENTRIES-1:0][ADDR_W-1:0] base;
    logic  [NUM_ENTRIES-1:0][ADDR_W-1:0] limit;
    logic  [NUM_ENTRIES-1:0]             match;
    logic  [NUM_ENTRIES-1:0]             allow;
    logic  [NUM_ENTRIES-1:0]             enab;

    hpc_regs #(
        .NUM      (NUM_ENTRIES),
        .AW       (ADDR_W),
        .HAS_MBIT (HAS_MBIT),
        .IW       (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_priv    (wr_priv),
        .wr_kind    (wr_kind),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .cfg_o      (cfg),
        .base_o     (base),
        .limit_o    (limit),
        .lockdown_o (lockdown)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        hpc_perm #(
            .AW (ADDR_W)
        ) u_perm (
            .cfg       (cfg[g]),
            .base      (base[g]),
            .limit     (limit[g]),
            .addr      (chk_addr),
            .acc       (chk_acc),
            .priv      (chk_priv),
            .lockdown  (lockdown),
            .match_o   (match[g]),
            .allow_o   (allow[g]),
            .enabled_o (enab[g])
        );
    end

    hpc_prio #(
        .NUM (NUM_ENTRIES),
        .IW  (IDX_W)
    ) u_prio (
        .match_i   (match),
        .allow_i   (allow),
        .enabled_i (enab),
        .is_mach   (chk_priv == PRIV_MACH),
        .hit_o     (chk_hit),
        .idx_o     (chk_idx),
        .fault_o   (chk_fault)
    );

    always_comb begin
        if (int'(rd_idx) < NUM_ENTRIES) begin
            rd_cfg   = cfg_to_byte(cfg[rd_idx]);
            rd_base  = base[rd_idx];
            rd_limit = limit[rd_idx];
        end else begin
            rd_cfg   = '0;
            rd_base  = '0;
            rd_limit = '0;
        end
    end

    AST_NOMATCH_MACH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_hit && (chk_priv == PRIV_MACH)) |-> !chk_fault)
        else $error("machine access faulted without a matching entry"); // R10

    AST_LOCKDOWN_BARS_MACH: assert property (@(posedge clk) disable iff (!rst_n)
        (lockdown && chk_hit && (chk_priv == PRIV_MACH) && !cfg[chk_idx].monly) |-> chk_fault)
        else $error("machine reached a supervisor/user region under lockdown"); // R9

endmodule

// File: tb/hart_prot_checker_bench.sv
module hart_prot_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM        = 4;
    localparam int AW         = 32;
    localparam int IW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_priv = 2'd3;
    logic [1:0]    wr_kind = 2'd0;
    logic [IW-1:0] wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [AW-1:0] chk_addr = '0;
    logic [1:0]    chk_acc = 2'd0;
    logic [1:0]    chk_priv = 2'd3;

    logic [7:0]    rd_cfg, n_rd_cfg;
    logic [AW-1:0] rd_base, rd_limit, n_rd_base, n_rd_limit;
    logic          lockdown, n_lockdown;
    logic          chk_fault, chk_hit, n_fault, n_hit;
    logic [IW-1:0] chk_idx, n_idx;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    // reference state
    logic [7:0]    m_cfg   [NUM];
    logic [AW-1:0] m_base  [NUM];
    logic [AW-1:0] m_limit [NUM];
    logic          m_ld;

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_prot_checker #(.NUM_ENTRIES(NUM), .ADDR_W(AW), .HAS_MBIT(1'b1)) u_hart_prot_checker (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_cfg(rd_cfg),
        .rd_base(rd_base), .rd_limit(rd_limit), .lockdown(lockdown), .chk_addr(chk_addr),
        .chk_acc(chk_acc), .chk_priv(chk_priv), .chk_fault(chk_fault), .chk_hit(chk_hit),
        .chk_idx(chk_idx));

    hart_prot_checker #(.NUM_ENTRIES(NUM), .ADDR_W(AW), .HAS_MBIT(1'b0)) u_hart_prot_checker_nom (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_cfg(n_rd_cfg),
        .rd_base(n_rd_base), .rd_limit(n_rd_limit), .lockdown(n_lockdown), .chk_addr(chk_addr),
        .chk_acc(chk_acc), .chk_priv(chk_priv), .chk_fault(n_fault), .chk_hit(n_hit),
        .chk_idx(n_idx));

    // behavioural model of the register side
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                m_cfg[i]   <= 8'h00;
                m_base[i]  <= '0;
                m_limit[i] <= '0;
            end
            m_ld <= 1'b0;
        end else if (wr_en && wr_priv == 2'd3) begin
            if (wr_kind == 2'd3) begin
                if (wr_data[0]) m_ld <= 1'b1;
            end else if (!m_cfg[wr_idx][7]) begin
                case (wr_kind)
                    2'd0:    m_cfg[wr_idx]   <= wr_data[7:0] & 8'h8F;
                    2'd1:    m_base[wr_idx]  <= wr_data;
                    default: m_limit[wr_idx] <= wr_data;
                endcase
            end
        end
    end

    task automatic check_val(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // register state compared against the model on every clock (R1, R2, R3, R4, R5)
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            check_val("R2/R4 readback cfg", {24'd0, rd_cfg}, {24'd0, m_cfg[rd_idx]});
            check_val("R2/R4 readback base", rd_base, m_base[rd_idx]);
            check_val("R2/R4 readback limit", rd_limit, m_limit[rd_idx]);
            check_val("R5 lockdown flag", {31'd0, lockdown}, {31'd0, m_ld});
        end
    end

    function automatic void ref_check(input logic [AW-1:0] a, input logic [1:0] acc,
                                      input logic [1:0] priv, output logic f,
                                      output logic h, output logic [IW-1:0] ix);
        logic any_en, en, p, ok, is_m;
        any_en = 1'b0;
        h  = 1'b0;
        ix = '0;
        f  = 1'b0;
        is_m = (priv == 2'd3);
        for (int i = 0; i < NUM; i++) begin
            en = |m_cfg[i][2:0];
            any_en = any_en | en;
            if (!h && en && a >= m_base[i] && a < m_limit[i]) begin
                h  = 1'b1;
                ix = IW'(i);
                p  = (acc == 2'd0) ? m_cfg[i][0] : (acc == 2'd1) ? m_cfg[i][1] : m_cfg[i][2];
                if (!m_ld) ok = (m_cfg[i][3] || m_cfg[i][7]) ? p : (is_m || p);
                else       ok = (m_cfg[i][3] == is_m) && p;
                f = !ok;
            end
        end
        if (!h) f = !(is_m || !any_en);
    endfunction

    task automatic chk_access(input logic [AW-1:0] a, input logic [1:0] acc,
                              input logic [1:0] priv, input string tag);
        logic ef, eh;
        logic [IW-1:0] ei;
        @(negedge clk);
        chk_addr = a;
        chk_acc  = acc;
        chk_priv = priv;
        #2;
        ref_check(a, acc, priv, ef, eh, ei);
        check_val({tag, " fault"}, {31'd0, chk_fault}, {31'd0, ef});
        check_val({tag, " hit"}, {31'd0, chk_hit}, {31'd0, eh});
        check_val({tag, " idx"}, {30'd0, chk_idx}, {30'd0, ei});
    endtask

    task automatic wr(input logic [1:0] kind, input int idx, input logic [AW-1:0] d,
                      input logic [1:0] priv);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_kind = kind;
        wr_idx  = IW'(idx);
        wr_data = d;
        wr_priv = priv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic peek(input int idx);
        @(negedge clk);
        rd_idx = IW'(idx);
        #2;
    endtask

    initial begin
        do_reset();

        // R1: reset state of every entry
        for (int i = 0; i < NUM; i++) begin
            peek(i);
            check_val("R1 cfg after reset", {24'd0, rd_cfg}, 32'h0);
            check_val("R1 base after reset", rd_base, 32'h0);
            check_val("R1 limit after reset", rd_limit, 32'h0);
        end
        check_val("R1 lockdown after reset", {31'd0, lockdown}, 32'h0);

        // R2: stored bits and base/limit write
        wr(2'd0, 2, 32'h7F, 2'd3);
        wr(2'd1, 2, 32'h1234, 2'd3);
        peek(2);
        check_val("R2 cfg bits 4..6 dropped", {24'd0, rd_cfg}, 32'h0F);
        check_val("R2 base stored", rd_base, 32'h1234);

        // R3: supervisor/user writes ignored
        wr(2'd0, 3, 32'h07, 2'd1);
        wr(2'd1, 3, 32'h55, 2'd0);
        wr(2'd3, 0, 32'h1, 2'd0);
        peek(3);
        check_val("R3 supervisor cfg write ignored", {24'd0, rd_cfg}, 32'h0);
        check_val("R3 user base write ignored", rd_base, 32'h0);
        check_val("R3 user lockdown write ignored", {31'd0, lockdown}, 32'h0);

        // R6: overlapping entries, lowest index decides
        do_reset();
        wr(2'd1, 0, 32'h100, 2'd3);
        wr(2'd2, 0, 32'h200, 2'd3);
        wr(2'd0, 0, 32'h01, 2'd3);
        wr(2'd1, 1, 32'h100, 2'd3);
        wr(2'd2, 1, 32'h300, 2'd3);
        wr(2'd0, 1, 32'h07, 2'd3);
        chk_access(32'h150, 2'd1, 2'd1, "R6 overlap low index");
        check_val("R6 overlap picks entry 0", {31'd0, chk_fault, 2'b0} | {30'd0, chk_idx}, 32'h4);
        chk_access(32'h250, 2'd1, 2'd1, "R6 second entry only");
        check_val("R6 second entry allows write", {30'd0, chk_idx, chk_fault}, 32'h2);

        // R4: lock freezes an entry
        wr(2'd0, 1, 32'h83, 2'd3);
        wr(2'd1, 1, 32'h0, 2'd3);
        wr(2'd0, 1, 32'h07, 2'd3);
        peek(1);
        check_val("R4 locked base kept", rd_base, 32'h100);
        check_val("R4 locked cfg kept", {24'd0, rd_cfg}, 32'h83);
        chk_access(32'h250, 2'd2, 2'd3, "R8 locked entry binds machine");
        check_val("R8 machine exec denied on locked RW entry", {31'd0, chk_fault}, 32'h1);

        // R10: no match
        chk_access(32'h50, 2'd0, 2'd3, "R10 no match machine");
        check_val("R10 machine allowed", {31'd0, chk_fault}, 32'h0);
        chk_access(32'h50, 2'd0, 2'd0, "R10 no match user");
        check_val("R10 user faults", {31'd0, chk_fault}, 32'h1);

        // R5: sticky lockdown
        wr(2'd3, 0, 32'h1, 2'd3);
        check_val("R5 lockdown set", {31'd0, lockdown}, 32'h1);
        wr(2'd3, 0, 32'h0, 2'd3);
        check_val("R5 lockdown stays set", {31'd0, lockdown}, 32'h1);

        // R11: machine-only bit absent
        do_reset();
        wr(2'd1, 0, 32'h100, 2'd3);
        wr(2'd2, 0, 32'h200, 2'd3);
        wr(2'd0, 0, 32'h09, 2'd3);
        peek(0);
        check_val("R11 M bit reads zero", {24'd0, n_rd_cfg}, 32'h01);
        chk_access(32'h180, 2'd1, 2'd3, "R8 M=1 binds machine");
        check_val("R11 machine write allowed without M bit", {31'd0, n_fault}, 32'h0);
        check_val("R8 machine write denied with M bit", {31'd0, chk_fault}, 32'h1);

        // R7/R8/R9/R10 sweep over all M/L/R/W/X codes, both lockdown states
        for (int ld = 0; ld < 2; ld++) begin
            for (int c = 0; c < 32; c++) begin
                logic [7:0] cb;
                string tag;
                cb = {c[4], 3'b000, c[3:0]};
                do_reset();
                wr(2'd1, 0, 32'h100, 2'd3);
                wr(2'd2, 0, 32'h200, 2'd3);
                if (ld == 1) wr(2'd3, 0, 32'h1, 2'd3);
                wr(2'd0, 0, {24'd0, cb}, 2'd3);
                if (ld == 1)                 tag = "R9 lockdown table";
                else if (cb[3] || cb[7])     tag = "R8 all-level table";
                else                         tag = "R7 legacy unlocked table";
                for (int pv = 0; pv < 3; pv++) begin
                    logic [1:0] pr;
                    pr = (pv == 2) ? 2'd3 : 2'(pv);
                    for (int ac = 0; ac < 3; ac++) begin
                        chk_access(32'h180, 2'(ac), pr, tag);
                    end
                    chk_access(32'h200, 2'd0, pr, "R10 limit is exclusive");
                    chk_access(32'h0FF, 2'd2, pr, "R10 below base");
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule